// File: doc/BRIEF.md
# Boundary Scan Data Register with Pin Multiplexing

This block is the test data path placed between a microcontroller core and its bidirectional port pins. A chain of single-bit scan cells is loaded in parallel when the TAP controller is in Capture-DR. The chain moves one position toward the serial output on every rising test-clock edge in Shift-DR. In Update-DR, on the falling edge, its contents are copied into a bank of shadow latches. The instruction register and the TAP state machine live elsewhere. This block only receives one already decoded signal per supported instruction and one strobe per relevant TAP state.

Every pin owns two neighbouring cells. The even cell holds the output enable and the odd cell holds the output level. Pin pairs follow one another in port order and then in bit order within each port. Spare pairs with no physical pin come next, so the chain length stays the same across package variants. The last cell, nearest the serial input, controls the global weak-pullup enable. When the external-test instruction is active, the pads are driven only from the shadow latches, and every signal from a pin into the core is forced high. The sampling instruction only captures and preloads the latches. With any other instruction the chain is idle and the core talks to the pins directly.

Top module: `bsr_top`

## Requirements
- R1: A synchronous active-high `tap_rst` clears the chain and the shadow latches, so that selecting external test right after reset drives every pad output enable to 0, every pad output level to 0 and `pad_wpu_en` to 0.
- R2: On a rising `tck` with `st_capture` high and a scan instruction selected, cell 2p loads `core_oe[p]` and cell 2p+1 loads `pad_di[p]`. Spare cells load 0, and the top cell (index LEN-1) loads `core_wpu_en`.
- R3: On a rising `tck` with `st_shift` high, `st_capture` low and a scan instruction selected, every cell takes the value of its upper neighbour, the top cell takes `tdi`, and `tdo` always shows cell 0. A bit entered on `tdi` therefore reaches `tdo` after exactly LEN = 2*(pins+spares)+1 shifts.
- R4: The shadow latches load the chain only on a falling `tck` while `st_update` is high and a scan instruction is selected. Shifting without an update leaves the pads unchanged.
- R5: While `instr_extest` is high, `pad_oe[p]` equals the latched cell 2p and `pad_do[p]` equals the latched cell 2p+1.
- R6: While `instr_extest` is high, `core_di` is all ones whatever the pins carry.
- R7: While `instr_extest` is high, `pad_wpu_en` equals the latched top cell. Otherwise it follows `core_wpu_en`.
- R8: While only `instr_sample` is high, the pads and `core_di` follow the core and the pins exactly as in functional mode, even when the latches are preloaded by an update.
- R9: With neither instruction high, the capture, shift and update strobes have no effect. `tdo` holds its value, the latches keep their contents, and the pads and core connect straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high test logic reset |
| instr_extest | input | 1 | Decoded external-test instruction (takes priority) |
| instr_sample | input | 1 | Decoded sample/preload instruction |
| st_capture | input | 1 | TAP is in Capture-DR |
| st_shift | input | 1 | TAP is in Shift-DR |
| st_update | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output (cell 0) |
| core_oe | input | NPINS | Output enables from the core |
| core_do | input | NPINS | Output levels from the core |
| core_di | output | NPINS | Pin levels delivered to the core |
| core_wpu_en | input | 1 | Core's global weak-pullup enable |
| pad_oe | output | NPINS | Output enables to the pads |
| pad_do | output | NPINS | Output levels to the pads |
| pad_di | input | NPINS | Levels read from the pads |
| pad_wpu_en | output | 1 | Global weak-pullup enable to the pads |

## Verification
Captures are tried with distinct output-enable and pin-level patterns (0xA5/0x3C, then 0x00/0xFF). A swapped or shifted cell mapping therefore shows up as a wrong bit in the scanned-out word. A capture-free shift of one pattern, followed by a second pattern, proves the chain length: the first word must reappear on `tdo` unchanged. Preloading under the sampling instruction and then switching to external test separates the latch load from the pad drive. Strobes sent while no scan instruction is active tell a correct idle state apart from one that leaks into the chain or the latches.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        BSR_FUNC   = 2'd0,
        BSR_SAMPLE = 2'd1,
        BSR_EXTEST = 2'd2
    } bsr_mode_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } bsr_ctl_t;

    function automatic bsr_mode_e decode_mode(input logic ext, input logic smp);
        if (ext)      return BSR_EXTEST;
        else if (smp) return BSR_SAMPLE;
        else          return BSR_FUNC;
    endfunction

    function automatic int oe_cell(input int pin);
        return 2 * pin;
    endfunction

    function automatic int dat_cell(input int pin);
        return 2 * pin + 1;
    endfunction

    function automatic int chain_len(input int npins, input int nspare);
        return 2 * (npins + nspare) + 1;
    endfunction

endpackage

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int NSPARE = 2
) (
    input  logic                 tck,
    input  logic                 rst,
    input  logic                 sel,
    input  bsr_ctl_t             ctl,
    input  logic [2*NPINS:0]     cap_in,
    input  logic                 tdi,
    output logic [2*NPINS:0]     par_out,
    output logic                 tdo
);
    localparam int LEN = chain_len(NPINS, NSPARE);
    localparam int VIS = 2 * NPINS + 1;

    logic [LEN-1:0] cells;
    logic [LEN-1:0] cap_full;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign cap_full[oe_cell(p)]  = cap_in[oe_cell(p)];
        assign cap_full[dat_cell(p)] = cap_in[dat_cell(p)];
        assign par_out[oe_cell(p)]   = cells[oe_cell(p)];
        assign par_out[dat_cell(p)]  = cells[dat_cell(p)];
    end

    for (genvar n = 0; n < NSPARE; n++) begin : g_spare
        assign cap_full[oe_cell(NPINS + n)]  = 1'b0;
        assign cap_full[dat_cell(NPINS + n)] = 1'b0;
    end

    assign cap_full[LEN-1] = cap_in[VIS-1];
    assign par_out[VIS-1]  = cells[LEN-1];

    always_ff @(posedge tck) begin
        if (rst)
            cells <= '0;
        else if (sel && ctl.capture)
            cells <= cap_full;
        else if (sel && ctl.shift)
            cells <= {tdi, cells[LEN-1:1]};
    end

    assign tdo = cells[0];
endmodule

// File: rtl/bsr_shadow.sv
module bsr_shadow #(
    parameter int W = 17
) (
    input  logic         tck,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(negedge tck) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/bsr_pinmux.sv
module bsr_pinmux
    import bsr_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  bsr_mode_e          mode,
    input  logic [NPINS-1:0]   lat_oe,
    input  logic [NPINS-1:0]   lat_do,
    input  logic               lat_wpu,
    input  logic [NPINS-1:0]   core_oe,
    input  logic [NPINS-1:0]   core_do,
    input  logic               core_wpu_en,
    input  logic [NPINS-1:0]   pad_di,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_do,
    output logic               pad_wpu_en,
    output logic [NPINS-1:0]   core_di
);
    always_comb begin
        if (mode == BSR_EXTEST) begin
            pad_oe     = lat_oe;
            pad_do     = lat_do;
            pad_wpu_en = lat_wpu;
            core_di    = '1;
        end else begin
            pad_oe     = core_oe;
            pad_do     = core_do;
            pad_wpu_en = core_wpu_en;
            core_di    = pad_di;
        end
    end
endmodule

// File: rtl/bsr_top.sv
module bsr_top
    import bsr_pkg::*;
#(
    parameter int PORTS  = 2,
    parameter int PORT_W = 4,
    parameter int NSPARE = 2
) (
    input  logic                      tck,
    input  logic                      tap_rst,
    input  logic                      instr_extest,
    input  logic                      instr_sample,
    input  logic                      st_capture,
    input  logic                      st_shift,
    input  logic                      st_update,
    input  logic                      tdi,
    output logic                      tdo,
    input  logic [PORTS*PORT_W-1:0]   core_oe,
    input  logic [PORTS*PORT_W-1:0]   core_do,
    output logic [PORTS*PORT_W-1:0]   core_di,
    input  logic                      core_wpu_en,
    output logic [PORTS*PORT_W-1:0]   pad_oe,
    output logic [PORTS*PORT_W-1:0]   pad_do,
    input  logic [PORTS*PORT_W-1:0]   pad_di,
    output logic                      pad_wpu_en
);
    localparam int NPINS = PORTS * PORT_W;
    localparam int VIS   = 2 * NPINS + 1;

    bsr_mode_e      mode;
    logic           sel;
    bsr_ctl_t       ctl;
    logic [VIS-1:0] cap_vec;
    logic [VIS-1:0] par_vec;
    logic [VIS-1:0] lat_vec;
    logic [NPINS-1:0] lat_oe;
    logic [NPINS-1:0] lat_do;

    assign mode = decode_mode(instr_extest, instr_sample);
    assign sel  = (mode != BSR_FUNC);
    assign ctl  = '{capture: st_capture, shift: st_shift, update: st_update};

    for (genvar p = 0; p < NPINS; p++) begin : g_map
        assign cap_vec[oe_cell(p)]  = core_oe[p];
        assign cap_vec[dat_cell(p)] = pad_di[p];
        assign lat_oe[p]            = lat_vec[oe_cell(p)];
        assign lat_do[p]            = lat_vec[dat_cell(p)];
    end
    assign cap_vec[VIS-1] = core_wpu_en;

    bsr_chain #(.NPINS(NPINS), .NSPARE(NSPARE)) u_chain (
        .tck     (tck),
        .rst     (tap_rst),
        .sel     (sel),
        .ctl     (ctl),
        .cap_in  (cap_vec),
        .tdi     (tdi),
        .par_out (par_vec),
        .tdo     (tdo)
    );

    bsr_shadow #(.W(VIS)) u_shadow (
        .tck  (tck),
        .rst  (tap_rst),
        .load (sel && ctl.update),
        .d    (par_vec),
        .q    (lat_vec)
    );

    bsr_pinmux #(.NPINS(NPINS)) u_mux (
        .mode        (mode),
        .lat_oe      (lat_oe),
        .lat_do      (lat_do),
        .lat_wpu     (lat_vec[VIS-1]),
        .core_oe     (core_oe),
        .core_do     (core_do),
        .core_wpu_en (core_wpu_en),
        .pad_di      (pad_di),
        .pad_oe      (pad_oe),
        .pad_do      (pad_do),
        .pad_wpu_en  (pad_wpu_en),
        .core_di     (core_di)
    );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
    parameter int NPINS = 8
) (
    input logic             tck,
    input logic             tap_rst,
    input logic             instr_extest,
    input logic             instr_sample,
    input logic             st_update,
    input logic             tdo,
    input logic [NPINS-1:0] core_oe,
    input logic [NPINS-1:0] core_do,
    input logic [NPINS-1:0] core_di,
    input logic             core_wpu_en,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_do,
    input logic             pad_wpu_en
);
    // R6: core side sees only ones under external test
    p_core_forced_r6: assert property (@(posedge tck) disable iff (tap_rst)
        instr_extest |-> (core_di == {NPINS{1'b1}}));

    // R8 and R9: outside external test the pads follow the core
    p_func_pins_r8: assert property (@(posedge tck) disable iff (tap_rst)
        !instr_extest |-> (pad_oe == core_oe && pad_do == core_do && pad_wpu_en == core_wpu_en));

    // R4: without an update strobe, driven pad values do not move
    p_latch_hold_r4: assert property (@(posedge tck) disable iff (tap_rst)
        (instr_extest && $past(instr_extest) && !st_update)
        |-> ($stable(pad_oe) && $stable(pad_do) && $stable(pad_wpu_en)));

    // R1: leaving reset straight into external test gives inactive enables
    p_reset_clear_r1: assert property (@(posedge tck) disable iff (tap_rst)
        ($fell(tap_rst) && instr_extest && !st_update) |-> (pad_oe == '0 && !pad_wpu_en));

    // R9: an unselected chain keeps its serial output
    p_idle_tdo_r9: assert property (@(posedge tck) disable iff (tap_rst)
        (!$past(instr_extest || instr_sample) && !$past(tap_rst)) |-> $stable(tdo));
endmodule

bind bsr_top bsr_checker #(.NPINS(NPINS)) u_bsr_chk (.*);

// File: tb/test_bsr_top.sv
`timescale 1ns/1ps
module test_bsr_top;
    localparam int PORTS  = 2;
    localparam int PORT_W = 4;
    localparam int NSPARE = 2;
    localparam int NPINS  = PORTS * PORT_W;
    localparam int LEN    = 2 * (NPINS + NSPARE) + 1;

    logic tck = 1'b0;
    logic tap_rst, instr_extest, instr_sample;
    logic st_capture, st_shift, st_update, tdi, tdo;
    logic [NPINS-1:0] core_oe, core_do, core_di, pad_oe, pad_do, pad_di;
    logic core_wpu_en, pad_wpu_en;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_en = 0;

    always #2.5 tck = ~tck;

    bsr_top #(.PORTS(PORTS), .PORT_W(PORT_W), .NSPARE(NSPARE)) i_bsr_top (
        .tck(tck), .tap_rst(tap_rst), .instr_extest(instr_extest), .instr_sample(instr_sample),
        .st_capture(st_capture), .st_shift(st_shift), .st_update(st_update),
        .tdi(tdi), .tdo(tdo), .core_oe(core_oe), .core_do(core_do), .core_di(core_di),
        .core_wpu_en(core_wpu_en), .pad_oe(pad_oe), .pad_do(pad_do), .pad_di(pad_di),
        .pad_wpu_en(pad_wpu_en)
    );

    // behavioural reference: queue front is the bit at tdo
    bit mq[$];
    bit m_oe[NPINS];
    bit m_do[NPINS];
    bit m_wpu;

    initial begin
        for (int i = 0; i < LEN; i++) mq.push_back(1'b0);
        for (int p = 0; p < NPINS; p++) begin m_oe[p] = 0; m_do[p] = 0; end
        m_wpu = 0;
    end

    always @(posedge tck) begin
        if (tap_rst) begin
            mq = {};
            for (int i = 0; i < LEN; i++) mq.push_back(1'b0);
        end else if (instr_extest || instr_sample) begin
            if (st_capture) begin
                mq = {};
                for (int p = 0; p < NPINS; p++) begin
                    mq.push_back(core_oe[p]);
                    mq.push_back(pad_di[p]);
                end
                for (int i = 0; i < 2 * NSPARE; i++) mq.push_back(1'b0);
                mq.push_back(core_wpu_en);
            end else if (st_shift) begin
                void'(mq.pop_front());
                mq.push_back(tdi);
            end
        end
    end

    always @(negedge tck) begin
        if (tap_rst) begin
            for (int p = 0; p < NPINS; p++) begin m_oe[p] = 0; m_do[p] = 0; end
            m_wpu = 0;
        end else if ((instr_extest || instr_sample) && st_update) begin
            for (int p = 0; p < NPINS; p++) begin m_oe[p] = mq[2*p]; m_do[p] = mq[2*p+1]; end
            m_wpu = mq[LEN-1];
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always begin
        @(negedge tck);
        #1;
        if (cmp_en) begin
            logic [NPINS-1:0] e_oe, e_do, e_di;
            logic e_wpu;
            string tag;
            if (instr_extest) begin
                for (int p = 0; p < NPINS; p++) begin e_oe[p] = m_oe[p]; e_do[p] = m_do[p]; end
                e_di = '1; e_wpu = m_wpu; tag = "R5";
            end else begin
                e_oe = core_oe; e_do = core_do; e_di = pad_di; e_wpu = core_wpu_en;
                tag = instr_sample ? "R8" : "R9";
            end
            check(tdo === mq[0], "R3", "tdo", 32'(tdo), 32'(mq[0]));
            check(pad_oe === e_oe, tag, "pad_oe", 32'(pad_oe), 32'(e_oe));
            check(pad_do === e_do, tag, "pad_do", 32'(pad_do), 32'(e_do));
            check(core_di === e_di, instr_extest ? "R6" : tag, "core_di", 32'(core_di), 32'(e_di));
            check(pad_wpu_en === e_wpu, "R7", "pad_wpu_en", 32'(pad_wpu_en), 32'(e_wpu));
        end
    end

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    function automatic logic [LEN-1:0] cap_word();
        logic [LEN-1:0] w = '0;
        for (int p = 0; p < NPINS; p++) begin w[2*p] = core_oe[p]; w[2*p+1] = pad_di[p]; end
        w[LEN-1] = core_wpu_en;
        return w;
    endfunction

    function automatic logic [NPINS-1:0] oe_of(input logic [LEN-1:0] w);
        logic [NPINS-1:0] r;
        for (int p = 0; p < NPINS; p++) r[p] = w[2*p];
        return r;
    endfunction

    function automatic logic [NPINS-1:0] do_of(input logic [LEN-1:0] w);
        logic [NPINS-1:0] r;
        for (int p = 0; p < NPINS; p++) r[p] = w[2*p+1];
        return r;
    endfunction

    task automatic shift_run(input logic [LEN-1:0] pat, input bit cap, output logic [LEN-1:0] got);
        if (cap) begin st_capture = 1; step(); st_capture = 0; end
        st_shift = 1;
        for (int i = 0; i < LEN; i++) begin
            got[i] = tdo;
            tdi = pat[i];
            step();
        end
        st_shift = 0;
        tdi = 0;
    endtask

    task automatic do_update();
        st_update = 1; step(); st_update = 0;
    endtask

    task automatic pads_are(input logic [LEN-1:0] w, input string tag);
        check(pad_oe === oe_of(w), tag, "pad_oe", 32'(pad_oe), 32'(oe_of(w)));
        check(pad_do === do_of(w), tag, "pad_do", 32'(pad_do), 32'(do_of(w)));
        check(pad_wpu_en === w[LEN-1], "R7", "pad_wpu_en", 32'(pad_wpu_en), 32'(w[LEN-1]));
    endtask

    bit done = 0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [LEN-1:0] pat_a, pat_b, pat_c, got, exp_w;
        logic tdo_hold;
        for (int i = 0; i < LEN; i++) begin
            pat_a[i] = (i % 3 == 0);
            pat_b[i] = (i % 2 == 1);
            pat_c[i] = (i % 4 != 2);
        end
        tap_rst = 1; instr_extest = 0; instr_sample = 0;
        st_capture = 0; st_shift = 0; st_update = 0; tdi = 0;
        core_oe = '1; core_do = 8'h5A; pad_di = 8'h96; core_wpu_en = 1;
        repeat (3) step();
        tap_rst = 0;
        cmp_en = 1;

        // R1: latches cleared by reset
        instr_extest = 1; step();
        check(pad_oe === '0, "R1", "pad_oe", 32'(pad_oe), 0);
        check(pad_do === '0, "R1", "pad_do", 32'(pad_do), 0);
        check(pad_wpu_en === 1'b0, "R1", "pad_wpu_en", 32'(pad_wpu_en), 0);
        instr_extest = 0;

        // R2 / R8: capture under sample, preload, pads untouched
        instr_sample = 1; core_oe = 8'hA5; pad_di = 8'h3C; core_wpu_en = 1;
        exp_w = cap_word();
        shift_run(pat_a, 1, got);
        check(got === exp_w, "R2", "captured word", 32'(got), 32'(exp_w));
        do_update();
        check(pad_oe === core_oe, "R8", "pad_oe after preload", 32'(pad_oe), 32'(core_oe));
        check(core_di === pad_di, "R8", "core_di", 32'(core_di), 32'(pad_di));

        // R3: chain length, pattern A reappears after LEN shifts
        shift_run(pat_b, 0, got);
        check(got === pat_a, "R3", "shift-through", 32'(got), 32'(pat_a));

        // R5 / R6 / R7: external test drives preloaded word
        instr_sample = 0; instr_extest = 1; step();
        pads_are(pat_a, "R5");
        check(core_di === '1, "R6", "core_di", 32'(core_di), 32'hFF);
        do_update();
        pads_are(pat_b, "R4");

        // R2 under external test, R4 hold until update
        core_oe = 8'h00; pad_di = 8'hFF; core_wpu_en = 0;
        exp_w = cap_word();
        shift_run(pat_c, 1, got);
        check(got === exp_w, "R2", "captured word 2", 32'(got), 32'(exp_w));
        pads_are(pat_b, "R4");
        do_update();
        pads_are(pat_c, "R4");

        // R9: strobes ignored without a scan instruction
        instr_extest = 0; core_wpu_en = 1;
        step();
        tdo_hold = tdo;
        st_capture = 1; step(); st_capture = 0;
        st_shift = 1; tdi = 1; repeat (6) step(); st_shift = 0; tdi = 0;
        do_update();
        check(tdo === tdo_hold, "R9", "tdo idle", 32'(tdo), 32'(tdo_hold));
        check(pad_do === core_do, "R9", "pad_do", 32'(pad_do), 32'(core_do));
        instr_extest = 1; step();
        pads_are(pat_c, "R9");

        // R1: reset mid-run clears latches again
        tap_rst = 1; step(); tap_rst = 0; step();
        check(pad_oe === '0, "R1", "pad_oe after reset", 32'(pad_oe), 0);
        check(tdo === 1'b0, "R1", "tdo after reset", 32'(tdo), 0);

        repeat (2) step();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule